// File: doc/BRIEF.md
# Multiport Vector Queue with Reload

This block is a parameterized circular queue that moves several elements in and out in a single cycle. It sits between two stages of a wide pipeline in place of a plain register. Back-pressure is carried by counts alone, so neither stage needs separate stall-detection logic.

Each cycle the queue presents its oldest entries to the consumer on a vector of lanes, with a count of how many lanes are valid. It also tells the producer how many elements it can take this cycle. The producer supplies a vector and a push count, and the queue appends that many lanes in lane order. The consumer answers with a take count, meaning how many of the presented lanes it consumed. Those entries leave the head at the clock edge.

A reload input replaces the whole contents in one cycle from a supplied vector and count, for example on a pipeline flush. Requests that ask for more than the queue offered are trimmed to what was offered, and an error flag marks the cycle.

Top module: `vecq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the queue. Afterwards `out_vld_cnt` is 0 and `free_cnt` is min(DEPTH, LANES).
- R2: `out_vld_cnt` equals min(occupancy, LANES). Lane 0 of `out_data` (bits DW-1:0) holds the oldest entry and lane i holds the i-th oldest. Lanes at or above `out_vld_cnt` are don't-care.
- R3: `free_cnt` equals min(DEPTH − occupancy, LANES), taken from the occupancy at the start of the cycle. Entries taken in a cycle raise `free_cnt` only from the next cycle on.
- R4: With `push_cnt` = n, lanes 0..n−1 of `push_data` are appended in lane order behind the existing contents. They become visible from the cycle after the edge.
- R5: With `take_cnt` = k, the k oldest entries are removed at the edge. In the next cycle, lane 0 shows the entry that was in lane k.
- R6: A push and a take in the same cycle both take effect. Occupancy changes by push count minus take count.
- R7: Head and tail wrap modulo DEPTH (6 by default, not a power of two). First-in first-out order is preserved across any number of wraps.
- R8: When `reload` is high, all stored entries are discarded. Lanes 0..m−1 of `reload_data` become the complete contents, with m = `reload_cnt`. `push_cnt` and `take_cnt` are ignored in that cycle.
- R9: A take count above `out_vld_cnt` removes only `out_vld_cnt` entries. A push count above `free_cnt` appends only the first `free_cnt` lanes. A reload count above LANES loads LANES lanes. `ovr_err` is high combinationally in any cycle with such a request, and low otherwise.
- R10: When occupancy reaches DEPTH, `free_cnt` is 0 and `out_vld_cnt` is LANES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_cnt | input | CW | Number of lanes of push_data to append |
| push_data | input | LANES*DW | Producer vector, lane i at bits i*DW +: DW |
| free_cnt | output | CW | Elements the queue can take this cycle |
| out_data | output | LANES*DW | Oldest entries, lane 0 oldest |
| out_vld_cnt | output | CW | Number of valid lanes in out_data |
| take_cnt | input | CW | Number of presented lanes consumed this cycle |
| reload | input | 1 | Replace all contents this cycle |
| reload_cnt | input | CW | Number of lanes of reload_data to load |
| reload_data | input | LANES*DW | Replacement contents, lane 0 becomes oldest |
| ovr_err | output | 1 | Request exceeded what was offered this cycle |

## Verification
The in-line properties watch these on every cycle:
- occupancy never exceeds the depth, and the queue is empty right after reset;
- the valid count after a reload follows the trimmed reload count;
- counts and the head entry stay frozen when no push or take occurs;
- a single take shifts lane 1 into lane 0.

Only the directed scenarios show the following, each against a reference model of the queue:
- full lane-order contents after pushes, takes and wraps;
- that reload discards a simultaneous push and take;
- that a trimmed push keeps only its first lanes;
- the exact cycles in which `ovr_err` rises.

// File: rtl/vecq_pkg.sv
package vecq_pkg;

    // Which vector feeds the storage write port this cycle
    typedef enum logic {
        SRC_PUSH   = 1'b0,
        SRC_RELOAD = 1'b1
    } wr_src_e;

    function automatic int min_int(int a, int b);
        return (a < b) ? a : b;
    endfunction

    // Pointer advance with wrap; n never exceeds depth
    function automatic int wrap_idx(int p, int n, int depth);
        int s;
        s = p + n;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/vecq_ctrl.sv
module vecq_ctrl
    import vecq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 6,
    localparam int CW = $clog2(LANES + 1),
    localparam int PW = $clog2(DEPTH),
    localparam int OW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] push_cnt,
    input  logic [CW-1:0] take_cnt,
    input  logic          reload,
    input  logic [CW-1:0] reload_cnt,
    output logic [PW-1:0] head_q_o,
    output logic [PW-1:0] wr_base,
    output logic [CW-1:0] wr_n,
    output wr_src_e       wr_src,
    output logic [CW-1:0] free_cnt,
    output logic [CW-1:0] vld_cnt,
    output logic          ovr_err
);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [OW-1:0] occ;
    } state_t;

    state_t st_d, st_q;

    int occ_i, vld_i, free_i, take_i, push_i, rcnt_i;
    int pop_n_i, push_n_i, rld_n_i;

    always_comb begin
        occ_i    = int'(st_q.occ);
        vld_i    = min_int(occ_i, LANES);
        free_i   = min_int(DEPTH - occ_i, LANES);
        take_i   = int'(take_cnt);
        push_i   = int'(push_cnt);
        rcnt_i   = int'(reload_cnt);
        pop_n_i  = min_int(take_i, vld_i);
        push_n_i = min_int(push_i, free_i);
        rld_n_i  = min_int(rcnt_i, LANES);

        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (reload) begin
            st_d.head = '0;
            st_d.tail = PW'(wrap_idx(0, rld_n_i, DEPTH));
            st_d.occ  = OW'(rld_n_i);
        end else begin
            st_d.head = PW'(wrap_idx(int'(st_q.head), pop_n_i, DEPTH));
            st_d.tail = PW'(wrap_idx(int'(st_q.tail), push_n_i, DEPTH));
            st_d.occ  = OW'(occ_i - pop_n_i + push_n_i);
        end

        wr_src   = reload ? SRC_RELOAD : SRC_PUSH;
        wr_base  = reload ? '0 : st_q.tail;
        wr_n     = (rst) ? '0 : (reload ? CW'(rld_n_i) : CW'(push_n_i));
        free_cnt = CW'(free_i);
        vld_cnt  = CW'(vld_i);
        ovr_err  = reload ? (rcnt_i > LANES)
                          : ((take_i > vld_i) || (push_i > free_i));
        head_q_o = st_q.head;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.occ) <= DEPTH);  // R10

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.occ == '0));  // R1

endmodule

// File: rtl/vecq_store.sv
module vecq_store
    import vecq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 6,
    parameter int DW    = 16,
    localparam int CW = $clog2(LANES + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PW-1:0]       wr_base,
    input  logic [CW-1:0]       wr_n,
    input  logic [LANES*DW-1:0] wr_data,
    output logic [DEPTH*DW-1:0] mem_q
);

    logic [DEPTH*DW-1:0] mem_d;
    logic [PW-1:0]       lane_addr [LANES];
    logic [LANES-1:0]    lane_en;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_addr[i] = PW'(wrap_idx(int'(wr_base), i, DEPTH));
        assign lane_en[i]   = (int'(wr_n) > i);
    end

    always_comb begin
        mem_d = mem_q;
        if (rst) begin
            mem_d = '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_en[i]) begin
                    mem_d[int'(lane_addr[i])*DW +: DW] = wr_data[i*DW +: DW];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/vecq_read.sv
module vecq_read
    import vecq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 6,
    parameter int DW    = 16,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic [PW-1:0]       head,
    input  logic [DEPTH*DW-1:0] mem,
    output logic [LANES*DW-1:0] out_data
);

    for (genvar i = 0; i < LANES; i++) begin : g_out
        logic [PW-1:0] rd_addr;
        assign rd_addr = PW'(wrap_idx(int'(head), i, DEPTH));
        assign out_data[i*DW +: DW] = mem[int'(rd_addr)*DW +: DW];
    end

endmodule

// File: rtl/vecq_top.sv
module vecq_top
    import vecq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 6,
    parameter int DW    = 16,
    localparam int CW = $clog2(LANES + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CW-1:0]       push_cnt,
    input  logic [LANES*DW-1:0] push_data,
    output logic [CW-1:0]       free_cnt,
    output logic [LANES*DW-1:0] out_data,
    output logic [CW-1:0]       out_vld_cnt,
    input  logic [CW-1:0]       take_cnt,
    input  logic                reload,
    input  logic [CW-1:0]       reload_cnt,
    input  logic [LANES*DW-1:0] reload_data,
    output logic                ovr_err
);

    logic [PW-1:0]       head;
    logic [PW-1:0]       wr_base;
    logic [CW-1:0]       wr_n;
    wr_src_e             wr_src;
    logic [LANES*DW-1:0] wr_data;
    logic [DEPTH*DW-1:0] mem;

    vecq_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .push_cnt   (push_cnt),
        .take_cnt   (take_cnt),
        .reload     (reload),
        .reload_cnt (reload_cnt),
        .head_q_o   (head),
        .wr_base    (wr_base),
        .wr_n       (wr_n),
        .wr_src     (wr_src),
        .free_cnt   (free_cnt),
        .vld_cnt    (out_vld_cnt),
        .ovr_err    (ovr_err)
    );

    assign wr_data = (wr_src == SRC_RELOAD) ? reload_data : push_data;

    vecq_store #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_base (wr_base),
        .wr_n    (wr_n),
        .wr_data (wr_data),
        .mem_q   (mem)
    );

    vecq_read #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) u_read (
        .head     (head),
        .mem      (mem),
        .out_data (out_data)
    );

    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
        reload |=> (out_vld_cnt == (($past(reload_cnt) > CW'(LANES)) ? CW'(LANES) : $past(reload_cnt))));  // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!reload && push_cnt == '0 && take_cnt == '0) |=> ($stable(free_cnt) && $stable(out_vld_cnt)));  // R3

    AST_HEAD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!reload && take_cnt == '0 && out_vld_cnt != '0) |=> (out_data[DW-1:0] == $past(out_data[DW-1:0])));  // R4

    if (LANES > 1) begin : g_shift_chk
        AST_POP_SHIFT: assert property (@(posedge clk) disable iff (rst)
            (!reload && take_cnt == CW'(1) && out_vld_cnt >= CW'(2)) |=> (out_data[DW-1:0] == $past(out_data[2*DW-1:DW])));  // R5
    end

endmodule

// File: tb/test_vecq_top.sv
`timescale 1ns/1ps
module test_vecq_top;

    localparam int LANES = 4;
    localparam int DEPTH = 6;
    localparam int DW    = 16;
    localparam int CW    = $clog2(LANES + 1);

    logic                clk = 1'b0;
    logic                rst;
    logic [CW-1:0]       push_cnt;
    logic [LANES*DW-1:0] push_data;
    logic [CW-1:0]       free_cnt;
    logic [LANES*DW-1:0] out_data;
    logic [CW-1:0]       out_vld_cnt;
    logic [CW-1:0]       take_cnt;
    logic                reload;
    logic [CW-1:0]       reload_cnt;
    logic [LANES*DW-1:0] reload_data;
    logic                ovr_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [DW-1:0] mq[$];

    always #2.5 clk = ~clk;

    vecq_top #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) i_vecq_top (
        .clk(clk), .rst(rst), .push_cnt(push_cnt), .push_data(push_data),
        .free_cnt(free_cnt), .out_data(out_data), .out_vld_cnt(out_vld_cnt),
        .take_cnt(take_cnt), .reload(reload), .reload_cnt(reload_cnt),
        .reload_data(reload_data), .ovr_err(ovr_err)
    );

    function automatic int mn(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare outputs that depend on stored state only
    task automatic check_state(string tag);
        int ev, ef;
        bit ok;
        ev = mn(mq.size(), LANES);
        ef = mn(DEPTH - mq.size(), LANES);
        chk(int'(out_vld_cnt) == ev, tag, "out_vld_cnt", int'(out_vld_cnt), ev);
        chk(int'(free_cnt) == ef, tag, "free_cnt", int'(free_cnt), ef);
        for (int i = 0; i < ev; i++) begin
            ok = (out_data[i*DW +: DW] == mq[i]);
            chk(ok, tag, $sformatf("lane%0d", i), int'(out_data[i*DW +: DW]), int'(mq[i]));
        end
    endtask

    // One cycle: drive, check the pre-edge counts and error, update model, check the result
    task automatic cyc(int pn, int base, int tk, bit rl, int rn, string tag);
        int ev, ef, np, nt, nr;
        bit eerr;
        @(negedge clk);
        push_cnt   = CW'(pn);
        take_cnt   = CW'(tk);
        reload     = rl;
        reload_cnt = CW'(rn);
        for (int i = 0; i < LANES; i++) begin
            push_data[i*DW +: DW]   = DW'(base + i);
            reload_data[i*DW +: DW] = DW'(base + 16'h80 + i);
        end
        #1;
        ev = mn(mq.size(), LANES);
        ef = mn(DEPTH - mq.size(), LANES);
        eerr = rl ? (rn > LANES) : ((tk > ev) || (pn > ef));
        chk(ovr_err == eerr, tag, "ovr_err", int'(ovr_err), int'(eerr));
        chk(int'(free_cnt) == ef, tag, "free_cnt before edge", int'(free_cnt), ef);
        @(posedge clk);
        #1;
        if (rl) begin
            mq.delete();
            nr = mn(rn, LANES);
            for (int i = 0; i < nr; i++) mq.push_back(DW'(base + 16'h80 + i));
        end else begin
            nt = mn(tk, ev);
            np = mn(pn, ef);
            for (int i = 0; i < nt; i++) void'(mq.pop_front());
            for (int i = 0; i < np; i++) mq.push_back(DW'(base + i));
        end
        check_state(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; push_cnt = '0; take_cnt = '0; reload = 1'b0; reload_cnt = '0;
        push_data = '0; reload_data = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        mq.delete();
        check_state("R1");
        chk(int'(free_cnt) == LANES, "R1", "free after reset", int'(free_cnt), LANES);
    endtask

    task automatic t_push_basic();
        cyc(3, 16'h10, 0, 0, 0, "R4");
        cyc(2, 16'h20, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, "R2");
    endtask

    task automatic t_pop();
        cyc(0, 0, 2, 0, 0, "R5");
        cyc(0, 0, 1, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, "R3");
    endtask

    task automatic t_push_pop();
        cyc(1, 16'h30, 0, 0, 0, "R6");
        cyc(3, 16'h40, 2, 0, 0, "R6");
        cyc(1, 16'h50, 1, 0, 0, "R3");
    endtask

    task automatic t_fill_full();
        cyc(4, 16'h60, 0, 0, 0, "R10");
        cyc(4, 16'h70, 0, 0, 0, "R10");
        chk(int'(free_cnt) == 0, "R10", "free when full", int'(free_cnt), 0);
        chk(int'(out_vld_cnt) == LANES, "R10", "vld when full", int'(out_vld_cnt), LANES);
        cyc(0, 0, 4, 0, 0, "R3");
    endtask

    task automatic t_wrap();
        for (int k = 0; k < 9; k++) cyc(2, 16'h100 + 16*k, 2, 0, 0, "R7");
        for (int k = 0; k < 5; k++) cyc(3, 16'h200 + 16*k, 3, 0, 0, "R7");
        cyc(0, 0, 4, 0, 0, "R7");
        cyc(0, 0, 4, 0, 0, "R7");
    endtask

    task automatic t_reload();
        cyc(4, 16'h300, 0, 0, 0, "R8");
        cyc(4, 16'h310, 4, 1, 3, "R8");
        cyc(0, 0, 0, 1, 0, "R8");
        cyc(2, 16'h320, 0, 0, 0, "R8");
        cyc(0, 16'h330, 0, 1, 4, "R8");
    endtask

    task automatic t_clamp();
        cyc(0, 0, 4, 1, 2, "R9");
        cyc(0, 0, 4, 0, 0, "R9");
        cyc(4, 16'h400, 0, 0, 0, "R9");
        cyc(1, 16'h410, 0, 0, 0, "R9");
        cyc(4, 16'h420, 0, 0, 0, "R9");
        cyc(0, 16'h430, 0, 1, 7, "R9");
        cyc(0, 0, 0, 0, 0, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_push_basic();
        t_pop();
        t_push_pop();
        t_fill_full();
        t_wrap();
        t_reload();
        t_clamp();
        t_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule